// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block keeps the 12-bit program counter of a small 4-bit controller core and a return stack of thirteen levels. Each cycle in which `step` is high, the decoder presents one instruction class with its operand field, its byte length and the current status flag. The block then moves the PC to the next sequential address, a conditional branch target, a short-call or long-call target, or an address popped from the stack. Calls push the return address. Interrupt entry pushes the address of the instruction it preempts, together with the flag nibble. Return from interrupt restores both and sets interrupt enable again.

The stack pointer holds the index of the newest entry. A push first decrements it and then writes the new level. A pop reads the level the pointer names and then increments it. Software may preset the pointer to any level. That level becomes the empty mark for later pops. A push with no free level, or a pop from an empty stack, is a stack fault. A fault raises a sticky flag and parks the block in a halt state until reset.

The controller has three named states. BOOT is entered on reset and lasts one cycle, in which the block accepts no instruction. The BOOT→RUN transition is unconditional. RUN is the working state. The RUN→HALT transition is taken on a stack overflow or underflow. HALT holds PC, pointer, enable and flags until reset.

Top module: `pc_stack_seq`

## Requirements
- R1: While reset is low and in the BOOT cycle that follows it, PC is 000h, `sp` is 13, `ie` is 0, `flags_out` is 0, and both fault flags are 0. A `step` during the BOOT cycle is ignored.
- R2: `op` is encoded as NEXT=0, BRANCH=1, SCALL=2, LCALL=3, RET=4, RETI=5, EI=6, DI=7. NEXT, EI and DI advance the PC by 1 when `len2`=0 and by 2 when `len2`=1, modulo 4096.
- R3: BRANCH loads `fld` into the PC when `sflag`=1. Otherwise it advances the PC by the instruction length.
- R4: SCALL with n=`fld[3:0]` jumps to 8n+6 for n=1..15 and to 086h for n=0. It pushes PC plus length and decrements `sp` by one.
- R5: LCALL jumps to `{0, fld[10:0]}`. It pushes PC plus length and decrements `sp` by one.
- R6: RET loads the PC from the entry at `sp` and increments `sp` by one.
- R7: With `ie`=1, a `step` that sees any `irq_req` bit is replaced by interrupt entry. The lowest set bit wins: bit0→002h, bit1→006h, bit2→00Ah, bit3→00Ch. Entry pushes the current PC with `flags_in`, clears `ie` and decrements `sp`. With `ie`=0, requests are ignored and the instruction executes.
- R8: RETI restores the PC and `flags_out` from the entry at `sp`, sets `ie` to 1 and increments `sp`.
- R9: EI sets `ie` and DI clears it.
- R10: `sp_load` with `step` low loads `min(sp_val, 13)` into `sp` and makes that level the empty mark. `sp_load` is ignored when `step` is high.
- R11: A push while `sp`=0 sets `stk_ovf`, leaves PC and `sp` unchanged and enters HALT.
- R12: A RET or RETI while `sp` equals the empty mark sets `stk_udf`, leaves PC and `sp` unchanged and enters HALT.
- R13: In HALT, `step` and `sp_load` have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction is presented this cycle |
| op | input | 3 | Instruction class |
| len2 | input | 1 | 1 = two-byte instruction, 0 = one byte |
| fld | input | 12 | Operand field (branch address, call address or short-call index) |
| sflag | input | 1 | Status flag that decides a branch |
| flags_in | input | 4 | Flag nibble saved on interrupt entry |
| irq_req | input | 4 | Interrupt requests, bit0 has the highest priority |
| sp_load | input | 1 | Preset the stack pointer |
| sp_val | input | 4 | Stack pointer preset value |
| pc | output | 12 | Program counter |
| sp | output | 4 | Stack pointer |
| ie | output | 1 | Interrupt enable |
| flags_out | output | 4 | Flag nibble restored by RETI |
| stk_ovf | output | 1 | Sticky stack overflow fault |
| stk_udf | output | 1 | Sticky stack underflow fault |

## Verification
Every result is a register, so PC, `sp`, `ie`, `flags_out` and both fault flags reflect a step on the first rising edge after it is presented, with exactly one cycle of latency. The bench drives inputs at the falling edge, lets one rising edge pass, and reads the outputs at the next falling edge. The BOOT cycle is the one exception: a `step` presented together with reset release must show no effect at that same sample point. Checks on the HALT state look one and two steps after the fault, to confirm that nothing moves.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_NEXT   = 3'd0,
        OP_BRANCH = 3'd1,
        OP_SCALL  = 3'd2,
        OP_LCALL  = 3'd3,
        OP_RET    = 3'd4,
        OP_RETI   = 3'd5,
        OP_EI     = 3'd6,
        OP_DI     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        S_BOOT = 2'd0,
        S_RUN  = 2'd1,
        S_HALT = 2'd2
    } st_e;

    // Entry address for interrupt source idx (idx 0 has the highest priority)
    function automatic logic [11:0] irq_vector(input int idx);
        case (idx)
            0:       return 12'h002;
            1:       return 12'h006;
            2:       return 12'h00A;
            default: return 12'h00C;
        endcase
    endfunction

endpackage

// File: rtl/pcs_target.sv
module pcs_target
    import pcs_pkg::*;
#(
    parameter int PCW = 12
) (
    input  op_e            opc,
    input  logic           len2,
    input  logic [PCW-1:0] fld,
    input  logic           sflag,
    input  logic [PCW-1:0] pc_cur,
    output logic [PCW-1:0] seq_pc,
    output logic [PCW-1:0] tgt_pc
);
    localparam logic [PCW-1:0] SC_ZERO = PCW'(12'h086);
    localparam logic [PCW-1:0] SC_OFS  = PCW'(6);

    logic [3:0]     sc_n;
    logic [PCW-1:0] sc_pc;
    logic [PCW-1:0] lc_pc;

    assign sc_n   = fld[3:0];
    assign seq_pc = pc_cur + (len2 ? PCW'(2) : PCW'(1));

    always_comb begin
        if (sc_n == 4'd0) begin
            sc_pc = SC_ZERO;
        end else begin
            sc_pc = (PCW'(sc_n) << 3) + SC_OFS;
        end
        lc_pc = {1'b0, fld[PCW-2:0]};
    end

    always_comb begin
        unique case (opc)
            OP_BRANCH: tgt_pc = sflag ? fld : seq_pc;
            OP_SCALL:  tgt_pc = sc_pc;
            OP_LCALL:  tgt_pc = lc_pc;
            default:   tgt_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/pcs_irq_pick.sv
module pcs_irq_pick
    import pcs_pkg::*;
#(
    parameter int NIRQ = 4,
    parameter int PCW  = 12
) (
    input  logic [NIRQ-1:0] req,
    input  logic            en,
    output logic            take,
    output logic [NIRQ-1:0] grant,
    output logic [PCW-1:0]  vec
);
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = PCW'(irq_vector(i));
            end
        end
        take = en && (req != '0);
    end

    // R7: at most one source is granted, and only when some request exists
    always_comb begin
        a_r7_grant_onehot : assert ($onehot0(grant) && ((grant != '0) == (req != '0)));
    end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int DEPTH = 13,
    parameter int W     = 16,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic           load,
    input  logic [SPW-1:0] load_val,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   rdata,
    output logic [SPW-1:0] sp,
    output logic           at_floor,
    output logic           at_base
);
    localparam logic [SPW-1:0] TOP = SPW'(DEPTH);

    logic [W-1:0]   mem [DEPTH];
    logic [SPW-1:0] sp_q;
    logic [SPW-1:0] base_q;
    logic [SPW-1:0] sp_dec;
    logic [SPW-1:0] ld_clamp;

    assign sp       = sp_q;
    assign sp_dec   = sp_q - SPW'(1);
    assign at_floor = (sp_q == '0);
    assign at_base  = (sp_q == base_q);
    assign ld_clamp = (load_val > TOP) ? TOP : load_val;
    assign rdata    = (sp_q < TOP) ? mem[sp_q] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= TOP;
            base_q <= TOP;
        end else if (load) begin
            sp_q   <= ld_clamp;
            base_q <= ld_clamp;
        end else if (push) begin
            sp_q <= sp_dec;
        end else if (pop) begin
            sp_q <= sp_q + SPW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !load) begin
            mem[sp_dec] <= wdata;
        end
    end

    a_r4_push_dec : assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load) |=> (sp_q == $past(sp_q) - SPW'(1)));

    a_r6_pop_inc : assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !load) |=> (sp_q == $past(sp_q) + SPW'(1)));

    a_r11_no_push_at_floor : assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !at_floor);

    a_r12_no_pop_at_base : assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !at_base);

    a_r10_sp_in_range : assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= TOP);

endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
    import pcs_pkg::*;
#(
    parameter int PCW   = 12,
    parameter int FLGW  = 4,
    parameter int NIRQ  = 4,
    parameter int DEPTH = 13,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [2:0]      op,
    input  logic            len2,
    input  logic [PCW-1:0]  fld,
    input  logic            sflag,
    input  logic [FLGW-1:0] flags_in,
    input  logic [NIRQ-1:0] irq_req,
    input  logic            sp_load,
    input  logic [SPW-1:0]  sp_val,
    output logic [PCW-1:0]  pc,
    output logic [SPW-1:0]  sp,
    output logic            ie,
    output logic [FLGW-1:0] flags_out,
    output logic            stk_ovf,
    output logic            stk_udf
);
    localparam int EW = PCW + FLGW;

    st_e             st_q, st_d;
    op_e             opc;
    logic [PCW-1:0]  pc_q, pc_d;
    logic            ie_q, ie_d;
    logic [FLGW-1:0] flg_q, flg_d;
    logic            ovf_q, udf_q;

    logic [PCW-1:0]  seq_pc, tgt_pc, vec;
    logic [NIRQ-1:0] grant;
    logic            take_raw;
    logic [EW-1:0]   wdata, rdata;
    logic            at_floor, at_base;

    logic run_step, is_call, is_ret;
    logic want_push, want_pop, ovf_hit, udf_hit;
    logic do_push, do_pop, do_load, fault;

    assign opc = op_e'(op);

    pcs_target #(.PCW(PCW)) u_tgt (
        .opc    (opc),
        .len2   (len2),
        .fld    (fld),
        .sflag  (sflag),
        .pc_cur (pc_q),
        .seq_pc (seq_pc),
        .tgt_pc (tgt_pc)
    );

    pcs_irq_pick #(.NIRQ(NIRQ), .PCW(PCW)) u_pick (
        .req   (irq_req),
        .en    (ie_q),
        .take  (take_raw),
        .grant (grant),
        .vec   (vec)
    );

    pcs_ret_stack #(.DEPTH(DEPTH), .W(EW)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .load     (do_load),
        .load_val (sp_val),
        .wdata    (wdata),
        .rdata    (rdata),
        .sp       (sp),
        .at_floor (at_floor),
        .at_base  (at_base)
    );

    // Control decode
    always_comb begin
        run_step  = (st_q == S_RUN) && step;
        is_call   = (opc == OP_SCALL) || (opc == OP_LCALL);
        is_ret    = (opc == OP_RET) || (opc == OP_RETI);
        want_push = run_step && (take_raw || is_call);
        want_pop  = run_step && !take_raw && is_ret;
        ovf_hit   = want_push && at_floor;
        udf_hit   = want_pop && at_base;
        fault     = ovf_hit || udf_hit;
        do_push   = want_push && !at_floor;
        do_pop    = want_pop && !at_base;
        do_load   = (st_q == S_RUN) && !step && sp_load;
        wdata     = {flags_in, (take_raw ? pc_q : seq_pc)};
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_BOOT;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_BOOT:  st_d = S_RUN;
            S_RUN:   st_d = fault ? S_HALT : S_RUN;
            S_HALT:  st_d = S_HALT;
            default: st_d = S_BOOT;
        endcase
    end

    // Next outputs
    always_comb begin
        pc_d  = pc_q;
        ie_d  = ie_q;
        flg_d = flg_q;
        if (run_step && !fault) begin
            if (take_raw) begin
                pc_d = vec;
                ie_d = 1'b0;
            end else begin
                unique case (opc)
                    OP_RET: begin
                        pc_d = rdata[PCW-1:0];
                    end
                    OP_RETI: begin
                        pc_d  = rdata[PCW-1:0];
                        flg_d = rdata[EW-1:PCW];
                        ie_d  = 1'b1;
                    end
                    OP_EI: begin
                        pc_d = tgt_pc;
                        ie_d = 1'b1;
                    end
                    OP_DI: begin
                        pc_d = tgt_pc;
                        ie_d = 1'b0;
                    end
                    default: begin
                        pc_d = tgt_pc;
                    end
                endcase
            end
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ie_q  <= 1'b0;
            flg_q <= '0;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            pc_q  <= pc_d;
            ie_q  <= ie_d;
            flg_q <= flg_d;
            if (ovf_hit) ovf_q <= 1'b1;
            if (udf_hit) udf_q <= 1'b1;
        end
    end

    assign pc        = pc_q;
    assign ie        = ie_q;
    assign flags_out = flg_q;
    assign stk_ovf   = ovf_q;
    assign stk_udf   = udf_q;

    a_r1_boot_clean : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BOOT) |-> (pc_q == '0 && !ie_q && !ovf_q && !udf_q));

    a_r7_entry_clears_ie : assert property (@(posedge clk) disable iff (!rst_n)
        (run_step && take_raw && !fault) |=> !ie_q);

    a_r8_reti_sets_ie : assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && opc == OP_RETI) |=> ie_q);

    a_r13_halt_freeze : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HALT) |=> ($stable(pc_q) && $stable(sp) && $stable(ie_q)));

    a_r11_fault_halts : assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hit || udf_hit) |=> (st_q == S_HALT));

endmodule

// File: tb/pc_stack_seq_test.sv
`timescale 1ns/1ps
module pc_stack_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        len2 = 1'b0;
    logic [11:0] fld = '0;
    logic        sflag = 1'b0;
    logic [3:0]  flags_in = '0;
    logic [3:0]  irq_req = '0;
    logic        sp_load = 1'b0;
    logic [3:0]  sp_val = '0;
    logic [11:0] pc;
    logic [3:0]  sp;
    logic        ie;
    logic [3:0]  flags_out;
    logic        stk_ovf, stk_udf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pc_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .step(step), .op(op), .len2(len2), .fld(fld),
        .sflag(sflag), .flags_in(flags_in), .irq_req(irq_req), .sp_load(sp_load),
        .sp_val(sp_val), .pc(pc), .sp(sp), .ie(ie), .flags_out(flags_out),
        .stk_ovf(stk_ovf), .stk_udf(stk_udf)
    );

    localparam logic [2:0] NX = 3'd0, BR = 3'd1, SC = 3'd2, LC = 3'd3,
                           RT = 3'd4, RI = 3'd5, EI = 3'd6, DI = 3'd7;

    // {op, len2, sflag, fld, exp_pc, exp_ie}; applied in order from PC 000h
    localparam logic [29:0] VEC [8] = '{
        {NX, 1'b0, 1'b0, 12'h000, 12'h001, 1'b0},  // R2 one byte
        {NX, 1'b1, 1'b0, 12'h000, 12'h003, 1'b0},  // R2 two bytes
        {BR, 1'b1, 1'b1, 12'h5A4, 12'h5A4, 1'b0},  // R3 taken
        {BR, 1'b1, 1'b0, 12'h123, 12'h5A6, 1'b0},  // R3 not taken
        {EI, 1'b0, 1'b0, 12'h000, 12'h5A7, 1'b1},  // R9 enable
        {DI, 1'b0, 1'b0, 12'h000, 12'h5A8, 1'b0},  // R9 disable
        {BR, 1'b1, 1'b1, 12'hFFE, 12'hFFE, 1'b0},  // R3 near top
        {NX, 1'b1, 1'b0, 12'h000, 12'h000, 1'b0}   // R2 wrap
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_step(input logic [2:0] o, input logic l2, input logic [11:0] f, input logic s);
        op = o; len2 = l2; fld = f; sflag = s; step = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic do_load(input logic [3:0] v);
        sp_val = v; sp_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sp_load = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step = 1'b0; sp_load = 1'b0; irq_req = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 pc", 32'(pc), 32'h000);
        check("R1 sp", 32'(sp), 32'd13);
        check("R1 ie", 32'(ie), 32'd0);
        check("R1 flags_out", 32'(flags_out), 32'd0);
        check("R1 faults", {30'd0, stk_ovf, stk_udf}, 32'd0);
        // R1 boot cycle ignores a step presented with reset release
        rst_n = 1'b1;
        op = BR; len2 = 1'b1; fld = 12'h100; sflag = 1'b1; step = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        check("R1 boot ignores step", 32'(pc), 32'h000);

        for (int i = 0; i < 8; i++) begin
            do_step(VEC[i][29:27], VEC[i][26], VEC[i][24:13], VEC[i][25]);
            check($sformatf("R2/R3/R9 vec%0d pc", i), 32'(pc), 32'(VEC[i][12:1]));
            check($sformatf("R2/R3/R9 vec%0d ie", i), 32'(ie), 32'(VEC[i][0]));
        end

        do_step(BR, 1'b1, 12'h100, 1'b1);
        check("R3 branch to 100", 32'(pc), 32'h100);
        do_step(SC, 1'b0, 12'h005, 1'b0);
        check("R4 scall n=5 pc", 32'(pc), 32'h02E);
        check("R4 scall sp", 32'(sp), 32'd12);
        do_step(SC, 1'b0, 12'h000, 1'b0);
        check("R4 scall n=0 pc", 32'(pc), 32'h086);
        check("R4 nested sp", 32'(sp), 32'd11);
        do_step(RT, 1'b0, 12'h000, 1'b0);
        check("R6 ret pc", 32'(pc), 32'h02F);
        check("R6 ret sp", 32'(sp), 32'd12);
        do_step(RT, 1'b0, 12'h000, 1'b0);
        check("R6 ret outer pc", 32'(pc), 32'h101);
        check("R6 ret outer sp", 32'(sp), 32'd13);
        do_step(LC, 1'b1, 12'hFAB, 1'b0);
        check("R5 lcall pc", 32'(pc), 32'h7AB);
        check("R5 lcall sp", 32'(sp), 32'd12);
        do_step(RT, 1'b0, 12'h000, 1'b0);
        check("R5 lcall return pc", 32'(pc), 32'h103);

        do_step(EI, 1'b0, 12'h000, 1'b0);
        check("R9 ei", 32'(ie), 32'd1);
        irq_req = 4'b1010; flags_in = 4'hA;
        do_step(NX, 1'b0, 12'h000, 1'b0);
        check("R7 timer vector", 32'(pc), 32'h006);
        check("R7 ie cleared", 32'(ie), 32'd0);
        check("R7 entry sp", 32'(sp), 32'd12);
        do_step(NX, 1'b0, 12'h000, 1'b0);
        check("R7 masked request ignored", 32'(pc), 32'h007);
        irq_req = 4'b0000;
        do_step(RI, 1'b0, 12'h000, 1'b0);
        check("R8 reti pc", 32'(pc), 32'h104);
        check("R8 reti ie", 32'(ie), 32'd1);
        check("R8 reti flags", 32'(flags_out), 32'hA);
        check("R8 reti sp", 32'(sp), 32'd13);

        irq_req = 4'b0100; flags_in = 4'h5;
        do_step(NX, 1'b0, 12'h000, 1'b0);
        check("R7 time base vector", 32'(pc), 32'h00A);
        irq_req = 4'b0000;
        do_step(RI, 1'b0, 12'h000, 1'b0);
        check("R8 flags 5", 32'(flags_out), 32'h5);
        irq_req = 4'b1000; flags_in = 4'h3;
        do_step(NX, 1'b0, 12'h000, 1'b0);
        check("R7 int1 vector", 32'(pc), 32'h00C);
        irq_req = 4'b0000;
        do_step(RI, 1'b0, 12'h000, 1'b0);
        check("R8 flags 3", 32'(flags_out), 32'h3);
        irq_req = 4'b1111;
        do_step(NX, 1'b0, 12'h000, 1'b0);
        check("R7 priority int0", 32'(pc), 32'h002);
        irq_req = 4'b0000;
        do_step(RI, 1'b0, 12'h000, 1'b0);
        check("R8 back to 104", 32'(pc), 32'h104);
        do_step(DI, 1'b0, 12'h000, 1'b0);
        check("R9 di", 32'(ie), 32'd0);
        check("R9 di pc", 32'(pc), 32'h105);

        // R12 underflow at the empty mark
        do_step(RT, 1'b0, 12'h000, 1'b0);
        check("R12 udf flag", 32'(stk_udf), 32'd1);
        check("R12 pc held", 32'(pc), 32'h105);
        check("R12 sp held", 32'(sp), 32'd13);
        do_step(BR, 1'b1, 12'h777, 1'b1);
        check("R13 halt ignores step", 32'(pc), 32'h105);
        do_load(4'd4);
        check("R13 halt ignores sp_load", 32'(sp), 32'd13);

        // R10 preset and R11 overflow
        do_reset();
        do_load(4'd2);
        check("R10 preset sp", 32'(sp), 32'd2);
        sp_val = 4'd5; sp_load = 1'b1;
        do_step(NX, 1'b0, 12'h000, 1'b0);
        sp_load = 1'b0;
        check("R10 load ignored with step", 32'(sp), 32'd2);
        check("R10 step still ran", 32'(pc), 32'h001);
        do_step(SC, 1'b0, 12'h001, 1'b0);
        check("R4 scall n=1", 32'(pc), 32'h00E);
        do_step(SC, 1'b0, 12'h00F, 1'b0);
        check("R4 scall n=15", 32'(pc), 32'h07E);
        check("R11 sp at floor", 32'(sp), 32'd0);
        check("R11 no fault yet", 32'(stk_ovf), 32'd0);
        do_step(SC, 1'b0, 12'h003, 1'b0);
        check("R11 ovf flag", 32'(stk_ovf), 32'd1);
        check("R11 pc held", 32'(pc), 32'h07E);
        check("R11 sp held", 32'(sp), 32'd0);
        do_step(RT, 1'b0, 12'h000, 1'b0);
        check("R13 halt ignores ret", 32'(pc), 32'h07E);

        do_reset();
        do_load(4'd15);
        check("R10 clamp to 13", 32'(sp), 32'd13);
        do_step(RI, 1'b0, 12'h000, 1'b0);
        check("R12 reti underflow", 32'(stk_udf), 32'd1);
        check("R12 reti keeps ie", 32'(ie), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule